// File: doc/BRIEF.md
# Path Status Byte Generator with Remote Error Indication

This block builds the path status byte (G1) for an outbound concatenated SONET payload. Its upper nibble carries the remote error indication (REI-P), which tells the far end how badly the path parity (B3) of the payload arriving at the local receiver was damaged. Once per received frame, the companion receive path presents two bytes: the B3 byte it took from the line and the BIP-8 it computed itself over the previous payload. It also raises a strobe. The block XORs the two bytes, counts the mismatched bits and keeps the result until the next frame.

When the transmit side raises a request, the block returns one G1 byte a cycle later. A two-bit insertion type picks where the REI-P nibble comes from. It can be the errored-bit count, a single clean/errored flag, or the upper nibble of a software G1 value register, limited to 8. The lower nibble of the outbound byte always comes from that register. The asynchronous active-low reset is synchronised inside the block before it reaches any logic.

Top module: `g1_status_gen`

## Requirements
- R1: While reset is held and after it is released, `g1_byte` is 0x00 and `g1_valid` is 0. The stored error count starts at 0, so a request in count mode before any frame strobe returns an upper nibble of 0.
- R2: With `ins_type` = 2'b00 (count mode), the upper nibble `g1_byte[7:4]` equals the number of set bits in `rx_b3 ^ rx_bip` at the most recent `frame_stb`, a value from 0 to 8.
- R3: With `ins_type` = 2'b10 (flag mode), `g1_byte[7:4]` is 4'd1 if the most recent strobed frame had at least one mismatched B3 bit, and 4'd0 otherwise.
- R4: With `ins_type` = 2'b01 (software mode), `g1_byte[7:4]` equals `g1_reg[7:4]` when that value is 8 or less, and equals 4'd8 when it is 9 to 15.
- R5: With `ins_type` = 2'b11, the block behaves exactly as in count mode.
- R6: In every mode, `g1_byte[3:0]` equals `g1_reg[3:0]` as sampled with the request.
- R7: The stored error result changes only on a cycle with `frame_stb` high. Changes to `rx_b3` or `rx_bip` without a strobe have no effect on later G1 bytes.
- R8: A request sampled high at a clock edge updates `g1_byte` and sets `g1_valid` for exactly one cycle, both visible after that edge. Without a request, `g1_byte` holds its value and `g1_valid` is 0.
- R9: When `frame_stb` and `g1_req` are high on the same edge, the G1 byte produced uses the error result of the previous frame. The new frame's result appears from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle strobe per received frame; captures the B3 comparison |
| rx_b3 | input | 8 | B3 byte received from the line |
| rx_bip | input | 8 | BIP-8 computed locally over the previous payload |
| ins_type | input | 2 | REI-P source: 00 count, 01 software, 10 flag, 11 count |
| g1_reg | input | 8 | Software G1 value; [7:4] REI-P in software mode, [3:0] lower nibble |
| g1_req | input | 1 | Transmit side asks for a G1 byte |
| g1_byte | output | 8 | Outbound G1 byte, registered |
| g1_valid | output | 1 | High for one cycle when g1_byte has been refreshed |

## Verification
A frame strobe updates the stored count at the edge that samples it, so the earliest request that can see the new result is one edge later. A request's byte and valid flag appear one edge after the request is sampled. The bench drives every input on the falling edge and holds it for one full cycle. It reads the outputs on the next falling edge, half a cycle after the edge that updated them. The same-edge case drives strobe and request together and expects the old result first, then the new one on the next request.

// File: rtl/g1_pkg.sv
package g1_pkg;
  typedef enum logic [1:0] {
    INS_COUNT     = 2'b00,
    INS_SOFTWARE  = 2'b01,
    INS_FLAG      = 2'b10,
    INS_COUNT_ALT = 2'b11
  } ins_mode_e;
endpackage

// File: rtl/g1_rst_sync.sv
module g1_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/g1_err_tracker.sv
module g1_err_tracker #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] rx_b3,
  input  logic [DATA_W-1:0] rx_bip,
  output logic [CNT_W-1:0]  err_cnt
);
  logic [DATA_W-1:0] diff;
  logic [CNT_W-1:0]  pop;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              cnt_en;

  always_comb begin
    diff = rx_b3 ^ rx_bip;
    pop  = '0;
    for (int i = 0; i < DATA_W; i++) pop = pop + CNT_W'(diff[i]);
  end

  always_comb begin
    cnt_en  = frame_stb;
    cnt_nxt = cnt_en ? pop : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign err_cnt = cnt_q;

  // R7: stored result moves only after a strobe
  a_r7_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(err_cnt));
  // R2: count never exceeds the byte width
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= CNT_W'(DATA_W));
  // R2: equal bytes on a strobe give zero errors
  a_r2_zero_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && rx_b3 == rx_bip) |=> err_cnt == '0);
endmodule

// File: rtl/g1_rei_select.sv
module g1_rei_select
  import g1_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int NIB_W = DATA_W / 2
) (
  input  logic [1:0]       ins_type,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic [NIB_W-1:0] sw_nib,
  output logic [NIB_W-1:0] rei
);
  localparam logic [NIB_W-1:0] REI_MAX = NIB_W'(DATA_W);

  ins_mode_e         mode;
  logic [NIB_W-1:0]  sw_clamped;
  logic [NIB_W-1:0]  cnt_nib;
  logic [NIB_W-1:0]  flag_nib;

  always_comb begin
    mode       = ins_mode_e'(ins_type);
    sw_clamped = (sw_nib > REI_MAX) ? REI_MAX : sw_nib;
    cnt_nib    = NIB_W'(err_cnt);
    flag_nib   = (err_cnt != '0) ? NIB_W'(1) : '0;
    case (mode)
      INS_SOFTWARE: rei = sw_clamped;
      INS_FLAG:     rei = flag_nib;
      default:      rei = cnt_nib;
    endcase
  end
endmodule

// File: rtl/g1_status_gen.sv
module g1_status_gen
  import g1_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] rx_b3,
  input  logic [DATA_W-1:0] rx_bip,
  input  logic [1:0]        ins_type,
  input  logic [DATA_W-1:0] g1_reg,
  input  logic              g1_req,
  output logic [DATA_W-1:0] g1_byte,
  output logic              g1_valid
);
  logic              rst_sync_n;
  logic [CNT_W-1:0]  err_cnt;
  logic [NIB_W-1:0]  rei;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] byte_nxt;
  logic              vld_q;
  logic              vld_nxt;

  g1_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  g1_err_tracker #(.DATA_W(DATA_W)) u_err_tracker (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (frame_stb),
    .rx_b3     (rx_b3),
    .rx_bip    (rx_bip),
    .err_cnt   (err_cnt)
  );

  g1_rei_select #(.DATA_W(DATA_W)) u_rei_select (
    .ins_type (ins_type),
    .err_cnt  (err_cnt),
    .sw_nib   (g1_reg[DATA_W-1:NIB_W]),
    .rei      (rei)
  );

  always_comb begin
    vld_nxt  = g1_req;
    byte_nxt = g1_req ? {rei, g1_reg[NIB_W-1:0]} : byte_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      byte_q <= byte_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign g1_byte  = byte_q;
  assign g1_valid = vld_q;

  // R8: a request yields a one-cycle valid
  a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    g1_req |=> g1_valid);
  // R8: output held and valid low without a request
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !g1_req |=> (!g1_valid && $stable(g1_byte)));
  // R6: lower nibble follows the register sampled with the request
  a_r6_low_nibble: assert property (@(posedge clk) disable iff (!rst_sync_n)
    g1_req |=> g1_byte[NIB_W-1:0] == $past(g1_reg[NIB_W-1:0]));
  // R4: REI-P never exceeds the byte width in any mode
  a_r4_rei_limit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    g1_valid |-> g1_byte[DATA_W-1:NIB_W] <= NIB_W'(DATA_W));
endmodule

// File: tb/test_g1_status_gen.sv
module test_g1_status_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_stb;
  logic [7:0] rx_b3, rx_bip, g1_reg, g1_byte;
  logic [1:0] ins_type;
  logic       g1_req, g1_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  g1_status_gen i_g1_status_gen (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_b3(rx_b3),
    .rx_bip(rx_bip), .ins_type(ins_type), .g1_reg(g1_reg),
    .g1_req(g1_req), .g1_byte(g1_byte), .g1_valid(g1_valid)
  );

  function automatic logic [3:0] popc(input logic [7:0] v);
    logic [3:0] c = '0;
    for (int i = 0; i < 8; i++) c = c + 4'(v[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b3, input logic [7:0] bip);
    @(negedge clk);
    rx_b3 = b3; rx_bip = bip; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  // request a byte; returns {valid, byte} sampled a half cycle after the update
  task automatic request(input logic [1:0] mode, input logic [7:0] reg_v, output logic [8:0] got);
    @(negedge clk);
    ins_type = mode; g1_reg = reg_v; g1_req = 1'b1;
    @(negedge clk);
    g1_req = 1'b0;
    got = {g1_valid, g1_byte};
  endtask

  task automatic t_reset();
    logic [8:0] g;
    check("R1 reset byte/valid", {g1_valid, g1_byte}, 9'h000);
    request(2'b00, 8'h00, g);
    check("R1 first count-mode REI", g, {1'b1, 4'd0, 4'h0});
  endtask

  task automatic t_count();
    logic [8:0] g;
    logic [7:0] b3s [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    logic [7:0] bps [4] = '{8'h00, 8'h00, 8'h24, 8'hC3};
    for (int i = 0; i < 4; i++) begin
      frame(b3s[i], bps[i]);
      request(2'b00, 8'h05, g);
      check("R2 count mode", g, {1'b1, popc(b3s[i] ^ bps[i]), 4'h5});
    end
  endtask

  task automatic t_flag();
    logic [8:0] g;
    frame(8'h10, 8'h00);
    request(2'b10, 8'h0A, g);
    check("R3 flag errored", g, {1'b1, 4'd1, 4'hA});
    frame(8'hFF, 8'h00);
    request(2'b10, 8'h0A, g);
    check("R3 flag all errored", g, {1'b1, 4'd1, 4'hA});
    frame(8'h5A, 8'h5A);
    request(2'b10, 8'h0A, g);
    check("R3 flag clean", g, {1'b1, 4'd0, 4'hA});
  endtask

  task automatic t_software();
    logic [8:0] g;
    frame(8'hF0, 8'h00);
    request(2'b01, 8'h03, g);
    check("R4 sw 0", g, {1'b1, 4'd0, 4'h3});
    request(2'b01, 8'h37, g);
    check("R4 sw 3", g, {1'b1, 4'd3, 4'h7});
    request(2'b01, 8'h8C, g);
    check("R4 sw 8", g, {1'b1, 4'd8, 4'hC});
    request(2'b01, 8'h91, g);
    check("R4 sw 9 clamp", g, {1'b1, 4'd8, 4'h1});
    request(2'b01, 8'hFE, g);
    check("R4 sw 15 clamp", g, {1'b1, 4'd8, 4'hE});
  endtask

  task automatic t_code11();
    logic [8:0] g;
    frame(8'h07, 8'h00);
    request(2'b11, 8'hF2, g);
    check("R5 code 11 as count", g, {1'b1, 4'd3, 4'h2});
  endtask

  task automatic t_low_nibble();
    logic [8:0] g;
    for (int m = 0; m < 4; m++) begin
      request(2'(m), {4'h0, 4'(m + 9)}, g);
      check("R6 low nibble", {1'b0, g[3:0]}, {5'b0, 4'(m + 9)});
    end
  endtask

  task automatic t_no_strobe();
    logic [8:0] g;
    frame(8'h03, 8'h00);
    @(negedge clk);
    rx_b3 = 8'hFF; rx_bip = 8'h00;
    repeat (3) @(negedge clk);
    request(2'b00, 8'h00, g);
    check("R7 no strobe ignored", g, {1'b1, 4'd2, 4'h0});
  endtask

  task automatic t_hold();
    logic [8:0] g;
    request(2'b00, 8'h06, g);
    @(negedge clk);
    g1_reg = 8'hFF; ins_type = 2'b01;
    @(negedge clk);
    check("R8 valid drops", {8'h00, g1_valid}, 9'h000);
    check("R8 byte held", {1'b0, g1_byte}, {1'b0, g[7:0]});
  endtask

  task automatic t_same_edge();
    logic [8:0] g;
    frame(8'h00, 8'h00);
    @(negedge clk);
    ins_type = 2'b00; g1_reg = 8'h00; g1_req = 1'b1;
    rx_b3 = 8'h1F; rx_bip = 8'h00; frame_stb = 1'b1;
    @(negedge clk);
    g1_req = 1'b0; frame_stb = 1'b0;
    check("R9 same edge old result", {g1_valid, g1_byte}, {1'b1, 4'd0, 4'h0});
    request(2'b00, 8'h00, g);
    check("R9 next request new result", g, {1'b1, 4'd5, 4'h0});
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; rx_b3 = '0; rx_bip = '0;
    ins_type = 2'b00; g1_reg = '0; g1_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {g1_valid, g1_byte}, 9'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_flag();
    t_software();
    t_code11();
    t_low_nibble();
    t_no_strobe();
    t_hold();
    t_same_edge();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule